// File: doc/BRIEF.md
# Buffered Pixel Word Unpacker

This block drains 64-bit memory words from a line buffer and turns them into a stream of narrower pixel words. Each pixel word comes with a one-cycle valid strobe. A parameter fixes the pixel width at 8, 24 or 32 bits. In 24-bit mode the pixels straddle the 64-bit word boundaries, so every group of three memory words yields exactly eight pixels. In the two power-of-two modes each word splits cleanly into two or eight pixels. Within each memory word the pixels are taken from the least significant bits upward.

A transfer begins with a request pulse that carries a byte count. The buffer side reports how many words it currently holds. The block waits for a start rule before reading anything. One variant starts once a fixed threshold of words is buffered, or once the whole transfer is buffered if that is smaller. The other variant waits for the whole transfer in every case. After the start, it reads words one at a time at increasing buffer indices from 0. Each read returns its data one cycle later, and no index is read before it is buffered. When the last pixel has been delivered, the block pulses done.

Top module: `pixel_unpack_top`

## Requirements
- R1: After reset, `pix_vld_o`, `done_o`, `rd_en_o` and `busy_o` are all low.
- R2: A request on `req_i` is taken only while `busy_o` is low, and `busy_o` is high in the cycle after a request is taken. A request made while busy is dropped and changes neither the pixel count nor the number of done pulses of the running transfer.
- R3: With `THRESH_EN`=1, the first buffer read of a transfer occurs once `fill_i` reaches `THRESH_WORDS` or the transfer's total word count (byte count / 8), whichever is smaller, and not before.
- R4: With `THRESH_EN`=0, the first buffer read of a transfer occurs only once `fill_i` has reached the transfer's total word count.
- R5: Reads use consecutive buffer indices starting at 0, one index per `rd_en_o` cycle, and an index is read only while it is below `fill_i`.
- R6: With `OUT_W`=24, pixel k is bits [24k+23:24k] of the word stream, in which word j occupies bits [64j+63:64j]. Three words therefore give eight pixels, and some pixels span two words.
- R7: With `OUT_W`=32, each word gives two pixels: bits [31:0] first, then bits [63:32].
- R8: With `OUT_W`=8, each word gives eight pixels, byte 0 (bits [7:0]) first.
- R9: A transfer of N bytes yields exactly N*8/`OUT_W` pixels. `pix_vld_o` is high for one cycle per pixel and only during a transfer.
- R10: `done_o` is a single-cycle pulse, issued once per transfer in the cycle right after the final `pix_vld_o`.
- R11: Back-to-back transfers are independent: the first pixel of each transfer comes from bit 0 of its buffer word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Transfer request pulse |
| req_bytes_i | input | CNT_W | Bytes to emit, sampled with the request |
| fill_i | input | CNT_W | Words currently held in the buffer for this transfer |
| rd_en_o | output | 1 | Buffer read enable |
| rd_addr_o | output | AW | Buffer word index to read |
| rd_data_i | input | IN_W | Buffer word, valid the cycle after `rd_en_o` |
| pix_o | output | OUT_W | Pixel word |
| pix_vld_o | output | 1 | Pixel valid, one cycle per pixel |
| done_o | output | 1 | Transfer complete pulse |
| busy_o | output | 1 | Transfer in progress |

## Verification
The riskiest overlap is a returning buffer word being merged into the bit accumulator in the same cycle that a pixel is shifted out of it. In 24-bit mode this happens on almost every word, and some of those pixels straddle two words. The bench keeps the block streaming by ramping `fill_i` slowly and also by presenting the whole transfer at once. The pixel streams from the 8, 24 and 32-bit instances are then compared bit for bit against pixels the bench builds from its own memory image. A second overlap is a request arriving while a transfer runs. The bench judges it by the pixel and done counts, and by the first pixel of the next transfer.

// File: rtl/pixel_unpack_pkg.sv
package pixel_unpack_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RUN} unpack_state_t;

  // buffer words that a byte count occupies (count is a multiple of 8)
  function automatic int unsigned words_of(int unsigned nbytes);
    return nbytes / 8;
  endfunction

  // pixels produced by a byte count at a given pixel width
  function automatic int unsigned outs_of(int unsigned nbytes, int unsigned out_w);
    return (nbytes * 8) / out_w;
  endfunction

  // start rule: whole transfer buffered, or threshold reached when enabled
  function automatic logic start_ok(int unsigned fill, int unsigned total,
                                    logic thr_en, int unsigned thr);
    return (fill >= total) || (thr_en && (fill >= thr));
  endfunction

endpackage

// File: rtl/pixel_unpack_shift.sv
module pixel_unpack_shift #(
  parameter int IN_W  = 64,
  parameter int OUT_W = 24,
  parameter int BW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             take_i,
  input  logic             load_i,
  input  logic [IN_W-1:0]  data_i,
  output logic [BW-1:0]    bits_o,
  output logic [OUT_W-1:0] head_o
);
  localparam int ACC_W = 2 * IN_W;

  logic [ACC_W-1:0] acc_q, acc_shr, acc_d;
  logic [BW-1:0]    bits_q, bits_mid, bits_d;

  always_comb begin
    acc_shr  = take_i ? (acc_q >> OUT_W) : acc_q;
    bits_mid = take_i ? (bits_q - BW'(OUT_W)) : bits_q;
    acc_d    = acc_shr;
    bits_d   = bits_mid;
    if (load_i) begin
      acc_d  = acc_shr | ({{IN_W{1'b0}}, data_i} << bits_mid);
      bits_d = bits_mid + BW'(IN_W);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      bits_q <= '0;
    end else if (clr_i) begin
      acc_q  <= '0;
      bits_q <= '0;
    end else begin
      acc_q  <= acc_d;
      bits_q <= bits_d;
    end
  end

  assign bits_o = bits_q;
  assign head_o = acc_q[OUT_W-1:0];

endmodule

// File: rtl/pixel_unpack_ctrl.sv
module pixel_unpack_ctrl
  import pixel_unpack_pkg::*;
#(
  parameter int IN_W         = 64,
  parameter int OUT_W        = 24,
  parameter int AW           = 8,
  parameter int CNT_W        = 12,
  parameter int BW           = 8,
  parameter int THRESH_EN    = 1,
  parameter int THRESH_WORDS = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [CNT_W-1:0] bytes_i,
  input  logic [CNT_W-1:0] fill_i,
  input  logic [BW-1:0]    bits_i,
  output logic             rd_en_o,
  output logic [AW-1:0]    rd_addr_o,
  output logic             take_o,
  output logic             load_o,
  output logic             accept_o,
  output logic             last_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] words_tot_o
);
  localparam int PW = BW + 1;

  unpack_state_t    st_q;
  logic [CNT_W-1:0] words_tot_q, issued_q, outs_left_q;
  logic             inflight_q;
  logic             start_go;
  logic [PW-1:0]    pend;

  generate
    if (THRESH_EN != 0) begin : g_thresh
      assign start_go = start_ok(32'(fill_i), 32'(words_tot_q), 1'b1, THRESH_WORDS);
    end else begin : g_whole
      assign start_go = start_ok(32'(fill_i), 32'(words_tot_q), 1'b0, THRESH_WORDS);
    end
  endgenerate

  assign accept_o = req_i && (st_q == ST_IDLE);
  assign take_o   = (st_q == ST_RUN) && (bits_i >= BW'(OUT_W)) && (outs_left_q != '0);
  assign last_o   = take_o && (outs_left_q == CNT_W'(1));

  // bits held or on their way, after this cycle's extraction
  assign pend = PW'(bits_i) + (inflight_q ? PW'(IN_W) : PW'(0))
              - (take_o ? PW'(OUT_W) : PW'(0));

  assign rd_en_o   = (st_q == ST_RUN) && (issued_q < words_tot_q) &&
                     (fill_i > issued_q) && (pend <= PW'(IN_W));
  assign rd_addr_o = issued_q[AW-1:0];
  assign load_o    = inflight_q;
  assign busy_o    = (st_q != ST_IDLE);
  assign words_tot_o = words_tot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      words_tot_q <= '0;
      issued_q    <= '0;
      outs_left_q <= '0;
      inflight_q  <= 1'b0;
    end else begin
      inflight_q <= rd_en_o;
      if (rd_en_o) issued_q <= issued_q + CNT_W'(1);
      if (take_o)  outs_left_q <= outs_left_q - CNT_W'(1);
      unique case (st_q)
        ST_IDLE: if (accept_o) begin
          words_tot_q <= CNT_W'(words_of(32'(bytes_i)));
          outs_left_q <= CNT_W'(outs_of(32'(bytes_i), OUT_W));
          issued_q    <= '0;
          st_q        <= ST_WAIT;
        end
        ST_WAIT: if (start_go) st_q <= ST_RUN;
        ST_RUN:  if (last_o)   st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pixel_unpack_top.sv
module pixel_unpack_top #(
  parameter int IN_W         = 64,
  parameter int OUT_W        = 24,
  parameter int AW           = 8,
  parameter int CNT_W        = 12,
  parameter int THRESH_EN    = 1,
  parameter int THRESH_WORDS = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [CNT_W-1:0] req_bytes_i,
  input  logic [CNT_W-1:0] fill_i,
  output logic             rd_en_o,
  output logic [AW-1:0]    rd_addr_o,
  input  logic [IN_W-1:0]  rd_data_i,
  output logic [OUT_W-1:0] pix_o,
  output logic             pix_vld_o,
  output logic             done_o,
  output logic             busy_o
);
  localparam int BW = $clog2(2 * IN_W + 1);

  // internal events, named for the checker
  logic             accept_w, take_w, load_w, last_w;
  logic [BW-1:0]    bits_w;
  logic [OUT_W-1:0] head_w;
  logic [CNT_W-1:0] words_tot_w;

  pixel_unpack_ctrl #(
    .IN_W(IN_W), .OUT_W(OUT_W), .AW(AW), .CNT_W(CNT_W), .BW(BW),
    .THRESH_EN(THRESH_EN), .THRESH_WORDS(THRESH_WORDS)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .bytes_i(req_bytes_i),
    .fill_i(fill_i), .bits_i(bits_w), .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o),
    .take_o(take_w), .load_o(load_w), .accept_o(accept_w), .last_o(last_w),
    .busy_o(busy_o), .words_tot_o(words_tot_w)
  );

  pixel_unpack_shift #(.IN_W(IN_W), .OUT_W(OUT_W), .BW(BW)) shift_i (
    .clk(clk), .rst_n(rst_n), .clr_i(accept_w), .take_i(take_w),
    .load_i(load_w), .data_i(rd_data_i), .bits_o(bits_w), .head_o(head_w)
  );

  logic [OUT_W-1:0] pix_q;
  logic             vld_q, fin_q, done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q  <= '0;
      vld_q  <= 1'b0;
      fin_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      vld_q  <= take_w;
      fin_q  <= last_w;
      done_q <= fin_q;
      if (take_w) pix_q <= head_w;
    end
  end

  assign pix_o     = pix_q;
  assign pix_vld_o = vld_q;
  assign done_o    = done_q;

endmodule

// File: rtl/pixel_unpack_chk.sv
module pixel_unpack_chk
  import pixel_unpack_pkg::*;
#(
  parameter int IN_W         = 64,
  parameter int AW           = 8,
  parameter int CNT_W        = 12,
  parameter int BW           = 8,
  parameter int THRESH_EN    = 1,
  parameter int THRESH_WORDS = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en_o,
  input logic [AW-1:0]    rd_addr_o,
  input logic [CNT_W-1:0] fill_i,
  input logic             pix_vld_o,
  input logic             done_o,
  input logic             busy_o,
  input logic             accept,
  input logic [CNT_W-1:0] words_tot,
  input logic [BW-1:0]    acc_bits
);

  // R5
  rd_below_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |-> (32'(rd_addr_o) < 32'(fill_i)));

  // R3 R4
  start_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |-> start_ok(32'(fill_i), 32'(words_tot), (THRESH_EN != 0), THRESH_WORDS));

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy_o);

  // R9
  vld_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld_o |-> $past(busy_o));

  // R10
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(pix_vld_o) && !pix_vld_o));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(acc_bits) <= 32'(2 * IN_W));

endmodule

bind pixel_unpack_top pixel_unpack_chk #(
  .IN_W(IN_W), .AW(AW), .CNT_W(CNT_W), .BW(BW),
  .THRESH_EN(THRESH_EN), .THRESH_WORDS(THRESH_WORDS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o),
  .fill_i(fill_i), .pix_vld_o(pix_vld_o), .done_o(done_o), .busy_o(busy_o),
  .accept(accept_w), .words_tot(words_tot_w), .acc_bits(bits_w)
);

// File: tb/pixel_unpack_top_tb.sv
`timescale 1ns/1ps
module pixel_unpack_top_tb_top;
  localparam int AW = 8;
  localparam int CNT_W = 12;
  localparam int THR = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [CNT_W-1:0] req_bytes = '0;
  logic [CNT_W-1:0] fill = '0;
  logic [63:0] mem [0:(1<<AW)-1];

  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;

  // instance a: 24-bit threshold; b: 8-bit; c: 32-bit; f: 24-bit whole-transfer
  logic rd_a, rd_b, rd_c, rd_f;
  logic [AW-1:0] ad_a, ad_b, ad_c, ad_f;
  logic [63:0] dt_a, dt_b, dt_c, dt_f;
  logic [23:0] px_a, px_f;
  logic [7:0]  px_b;
  logic [31:0] px_c;
  logic vl_a, vl_b, vl_c, vl_f, dn_a, dn_b, dn_c, dn_f, bz_a, bz_b, bz_c, bz_f;

  pixel_unpack_top #(.OUT_W(24), .THRESH_EN(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .req_bytes_i(req_bytes), .fill_i(fill),
    .rd_en_o(rd_a), .rd_addr_o(ad_a), .rd_data_i(dt_a), .pix_o(px_a),
    .pix_vld_o(vl_a), .done_o(dn_a), .busy_o(bz_a));
  pixel_unpack_top #(.OUT_W(8), .THRESH_EN(1)) dut8_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .req_bytes_i(req_bytes), .fill_i(fill),
    .rd_en_o(rd_b), .rd_addr_o(ad_b), .rd_data_i(dt_b), .pix_o(px_b),
    .pix_vld_o(vl_b), .done_o(dn_b), .busy_o(bz_b));
  pixel_unpack_top #(.OUT_W(32), .THRESH_EN(1)) dut32_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .req_bytes_i(req_bytes), .fill_i(fill),
    .rd_en_o(rd_c), .rd_addr_o(ad_c), .rd_data_i(dt_c), .pix_o(px_c),
    .pix_vld_o(vl_c), .done_o(dn_c), .busy_o(bz_c));
  pixel_unpack_top #(.OUT_W(24), .THRESH_EN(0)) dutf_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .req_bytes_i(req_bytes), .fill_i(fill),
    .rd_en_o(rd_f), .rd_addr_o(ad_f), .rd_data_i(dt_f), .pix_o(px_f),
    .pix_vld_o(vl_f), .done_o(dn_f), .busy_o(bz_f));

  // buffer model: one-cycle read latency
  always @(posedge clk) begin
    if (rd_a) dt_a <= mem[ad_a];
    if (rd_b) dt_b <= mem[ad_b];
    if (rd_c) dt_c <= mem[ad_c];
    if (rd_f) dt_f <= mem[ad_f];
  end

  logic [31:0] q_a[$], q_b[$], q_c[$], q_f[$];
  int dcnt [4];
  int ffill [4];
  bit seen [4];
  int exp_addr;
  int rd_viol, dn_viol;
  bit pv_a;

  always @(negedge clk) if (rst_n) begin
    if (vl_a) q_a.push_back(32'(px_a));
    if (vl_b) q_b.push_back(32'(px_b));
    if (vl_c) q_c.push_back(px_c);
    if (vl_f) q_f.push_back(32'(px_f));
    if (dn_a) dcnt[0]++;
    if (dn_b) dcnt[1]++;
    if (dn_c) dcnt[2]++;
    if (dn_f) dcnt[3]++;
    if (rd_a && !seen[0]) begin seen[0] = 1; ffill[0] = int'(fill); end
    if (rd_f && !seen[3]) begin seen[3] = 1; ffill[3] = int'(fill); end
    if (rd_a) begin
      if (int'(ad_a) != exp_addr || int'(ad_a) >= int'(fill)) rd_viol++;
      exp_addr++;
    end
    if (dn_a && !pv_a) dn_viol++;
    pv_a = vl_a;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // pixel k of width w from the word stream, LSB of word 0 first
  function automatic logic [31:0] exp_pix(input int w, input int k);
    logic [31:0] r = '0;
    for (int b = 0; b < w; b++) begin
      int i = k * w + b;
      r[b] = mem[i / 64][i % 64];
    end
    return r;
  endfunction

  task automatic cmp_stream(input string tag, input int w, input int nbytes,
                            ref logic [31:0] q[$]);
    int n = nbytes * 8 / w;
    int bad_k = -1;
    check(q.size() == n, "R9", {tag, " pixel count"}, q.size(), n);
    for (int k = 0; k < q.size() && k < n; k++)
      if (bad_k < 0 && q[k] != exp_pix(w, k)) bad_k = k;
    if (bad_k >= 0)
      check(1'b0, tag, $sformatf("pixel %0d", bad_k), q[bad_k], exp_pix(w, bad_k));
    else
      check(1'b1, tag, "pixels", 0, 0);
  endtask

  int xfer_no = 0;

  task automatic run_xfer(input int nbytes, input bit ramp, input bit spur);
    int words = nbytes / 8;
    int guard = 0;
    for (int i = 0; i < words; i++) mem[i] = {$urandom, $urandom};
    q_a.delete(); q_b.delete(); q_c.delete(); q_f.delete();
    for (int i = 0; i < 4; i++) begin dcnt[i] = 0; seen[i] = 0; ffill[i] = -1; end
    exp_addr = 0; rd_viol = 0; dn_viol = 0;
    @(negedge clk);
    req = 1'b1; req_bytes = CNT_W'(nbytes); fill = ramp ? '0 : CNT_W'(words);
    @(negedge clk);
    req = 1'b0;
    if (spur) begin
      @(negedge clk);
      req = 1'b1; req_bytes = CNT_W'(nbytes + 48);
      @(negedge clk);
      req = 1'b0;
    end
    if (ramp)
      for (int i = 1; i <= words; i++) begin
        repeat (2) @(negedge clk);
        fill = CNT_W'(i);
      end
    while (!(dcnt[0] > 0 && dcnt[1] > 0 && dcnt[2] > 0 && dcnt[3] > 0) && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    check(guard < 20000, "R10", "transfer completion", guard, 0);
    repeat (4) @(negedge clk);
    cmp_stream("R6", 24, nbytes, q_a);
    cmp_stream("R8", 8, nbytes, q_b);
    cmp_stream("R7", 32, nbytes, q_c);
    cmp_stream("R4", 24, nbytes, q_f);
    check(dcnt[0] == 1 && dcnt[1] == 1 && dcnt[2] == 1 && dcnt[3] == 1, "R10",
          "done pulses", dcnt[0] + dcnt[1] + dcnt[2] + dcnt[3], 4);
    check(dn_viol == 0, "R10", "done not after final valid", dn_viol, 0);
    check(rd_viol == 0, "R5", "read index order/fill violations", rd_viol, 0);
    if (ramp) begin
      int lo = (words < THR) ? words : THR;
      check(ffill[0] >= lo && ffill[0] <= lo + 1, "R3", "fill at first read", ffill[0], lo);
    end
    check(ffill[3] == words, "R4", "fill at first read", ffill[3], words);
    if (spur)
      check(q_a.size() == nbytes / 3 && dcnt[0] == 1, "R2", "busy request effect",
            q_a.size(), nbytes / 3);
    if (xfer_no > 0 && q_a.size() > 0)
      check(q_a[0] == exp_pix(24, 0), "R11", "first pixel of new transfer", q_a[0], exp_pix(24, 0));
    xfer_no++;
    fill = '0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    check(!vl_a && !dn_a && !rd_a && !bz_a && !vl_b && !bz_b && !vl_c && !bz_c && !bz_f,
          "R1", "outputs in reset", {vl_a, dn_a, rd_a, bz_a}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!vl_a && !dn_a && !rd_a && !bz_a, "R1", "outputs after reset",
          {vl_a, dn_a, rd_a, bz_a}, 0);
    run_xfer(24, 1'b1, 1'b0);    // smallest legal transfer, three words
    run_xfer(72, 1'b1, 1'b0);    // below threshold, ramped
    run_xfer(768, 1'b1, 1'b0);   // 96 words, threshold start
    run_xfer(384, 1'b1, 1'b1);   // exactly the threshold, request while busy
    run_xfer(1152, 1'b0, 1'b1);  // all buffered at once
    for (int t = 0; t < 8; t++)
      run_xfer(24 * (1 + int'($urandom % 40)), 1'($urandom % 2), 1'($urandom % 2));
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule